// File: doc/BRIEF.md
# Bus Interface Status and Mode Register

This block holds the status and mode word of a two-wire serial bus interface as one CPU-visible 8-bit register. The word holds the master/slave selection, the transmit/receive direction and the bus-busy flag. It also holds four read-only flags (last received bit, general call seen, own address matched, arbitration lost) and an active-low interrupt request flag.

The bus engine around the block reports what happens on the wires through single-cycle strobes: START seen, STOP seen, arbitration lost, missing acknowledge, end of an address byte with its R/W bit, one data bit received, end of a byte, a START suppressed because another master already started, and an interrupt request. The CPU writes the word through a plain write strobe and reads it continuously on `status`.

The block applies the hardware set and clear rules itself. A hardware event always beats a software write to the same bit in the same cycle. All pins are plain control and status signals; no data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset `status` reads 0x10: the interrupt flag (bit 4) is 1, meaning no request, and every other bit is 0.
- R2: Bit 7 selects master (1) or slave (0) and bit 6 selects transmit (1) or receive (0), so 00 is slave receive, 01 slave transmit, 10 master receive and 11 master transmit. A write loads both bits from `wr_data[7:6]` on the next clock.
- R3: The busy flag (bit 5) goes to 1 the cycle after `ev_start` and to 0 the cycle after `ev_stop`. A STOP in the same cycle as a START wins.
- R4: While `if_enable` is 0 the busy flag is 0 from the next clock on, whatever the events or writes.
- R5: A write changes the busy flag only if that same write selects master transmit (`wr_data[7:6]` = 11). Otherwise the busy flag keeps its value.
- R6: The transmit bit is cleared by `ev_arb_lost`, `ev_stop` or `ev_start_blocked`. It is also cleared by `ev_start` or `ev_nack` when bit 7 is 0.
- R7: The master bit is cleared by `ev_stop` or `ev_start_blocked`. After `ev_arb_lost` it is cleared at the first later `ev_byte_done`, not at the loss itself.
- R8: In slave receive mode with `addr_only` low, `ev_addr_done` loads the transmit bit from `addr_rw`. With `addr_only` high, or in any other mode, the transmit bit does not follow `addr_rw`.
- R9: A write has no effect on bits 3:0. Bit 0 loads `bit_val` on `ev_bit_rx`. Bits 1 and 2 load `addr_gcall` and `addr_match` on `ev_addr_done` and are cleared by `ev_stop`. Bit 3 is set by `ev_arb_lost` and cleared by `ev_start`, and the set wins when both occur.
- R10: Bit 4 goes to 0 (request issued) on `ev_irq`, or on `ev_stop` while bit 7 is 0. A write loads bit 4 from `wr_data[4]`.
- R11: When a hardware event and a write touch the same bit in the same cycle, the hardware result is what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_enable | input | 1 | Interface enable; 0 holds busy flag at 0 |
| addr_only | input | 1 | Address-only mode; 1 stops R/W capture into the transmit bit |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| ev_start | input | 1 | START detected |
| ev_stop | input | 1 | STOP detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_nack | input | 1 | Acknowledge not returned |
| ev_addr_done | input | 1 | Address byte received |
| addr_rw | input | 1 | R/W bit of that address byte |
| addr_gcall | input | 1 | Address byte was a general call |
| addr_match | input | 1 | Address byte matched own address |
| ev_bit_rx | input | 1 | One bit received |
| bit_val | input | 1 | Value of that bit |
| ev_byte_done | input | 1 | Current byte finished |
| ev_start_blocked | input | 1 | START suppressed by duplicate-START prevention |
| ev_irq | input | 1 | Interrupt request from the bus engine |
| status | output | 8 | Register contents |

## Verification
The hardest state to reach from the ports is the deferred master clear. An arbitration loss only arms a pending clear, and that clear fires on a later byte-end strobe. The stimulus enters master transmit by a write, raises `ev_arb_lost`, idles for some cycles while the master bit must stay set, and then pulses `ev_byte_done`. Same-cycle collisions between writes and hardware strobes are built directly, and a long random phase then mixes every strobe against the bench's cycle model.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned BIT_LAST   = 0;
  localparam int unsigned BIT_GCALL  = 1;
  localparam int unsigned BIT_MATCH  = 2;
  localparam int unsigned BIT_ARB    = 3;
  localparam int unsigned BIT_IRQN   = 4;
  localparam int unsigned BIT_BUSY   = 5;
  localparam int unsigned BIT_XMIT   = 6;
  localparam int unsigned BIT_MASTER = 7;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic arb_lost;
    logic nack;
    logic addr_done;
    logic addr_rw;
    logic addr_gcall;
    logic addr_match;
    logic bit_rx;
    logic bit_val;
    logic byte_done;
    logic start_blocked;
    logic irq;
  } bus_ev_t;
endpackage

// File: rtl/i2cs_mode.sv
module i2cs_mode
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev,
  input  logic    addr_only,
  input  logic    wr_en,
  input  mode_e   wr_mode,
  output mode_e   mode
);
  logic master_q, xmit_q, arb_wait_q;
  logic master_d, xmit_d, arb_wait_d;
  logic master_kill, xmit_kill, rw_take;

  // hardware clears, evaluated against the current mode
  assign master_kill = ev.stop | ev.start_blocked | (arb_wait_q & ev.byte_done);
  assign xmit_kill   = ev.arb_lost | ev.stop | ev.start_blocked |
                       (~master_q & (ev.start | ev.nack));
  assign rw_take     = ev.addr_done & ~addr_only & (mode == MODE_SLV_RX);

  always_comb begin
    master_d = master_q;
    if (wr_en) master_d = wr_mode[1];
    if (master_kill) master_d = 1'b0;

    xmit_d = xmit_q;
    if (wr_en) xmit_d = wr_mode[0];
    if (rw_take) xmit_d = ev.addr_rw;
    if (xmit_kill) xmit_d = 1'b0;

    arb_wait_d = arb_wait_q;
    if (arb_wait_q & ev.byte_done) arb_wait_d = 1'b0;
    if (ev.stop) arb_wait_d = 1'b0;
    if (ev.arb_lost) arb_wait_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q   <= 1'b0;
      xmit_q     <= 1'b0;
      arb_wait_q <= 1'b0;
    end else begin
      master_q   <= master_d;
      xmit_q     <= xmit_d;
      arb_wait_q <= arb_wait_d;
    end
  end

  assign mode = mode_e'({master_q, xmit_q});
endmodule

// File: rtl/i2cs_busy.sv
module i2cs_busy
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  bus_ev_t ev,
  input  logic    wr_en,
  input  mode_e   wr_mode,
  input  logic    wr_busy,
  output logic    busy
);
  logic busy_d;

  always_comb begin
    busy_d = busy;
    if (wr_en && wr_mode == MODE_MST_TX) busy_d = wr_busy;
    if (ev.start) busy_d = 1'b1;
    if (ev.stop)  busy_d = 1'b0;
    if (!enable)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end
endmodule

// File: rtl/i2cs_flags.sv
module i2cs_flags
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_ev_t    ev,
  input  logic       is_master,
  input  logic       wr_en,
  input  logic       wr_irqn,
  output logic [4:0] flags
);
  logic [4:0] q, d;

  always_comb begin
    d = q;
    if (ev.bit_rx) d[BIT_LAST] = ev.bit_val;
    if (ev.addr_done) begin
      d[BIT_GCALL] = ev.addr_gcall;
      d[BIT_MATCH] = ev.addr_match;
    end
    if (ev.stop) begin
      d[BIT_GCALL] = 1'b0;
      d[BIT_MATCH] = 1'b0;
    end
    if (ev.start)    d[BIT_ARB] = 1'b0;
    if (ev.arb_lost) d[BIT_ARB] = 1'b1;
    if (wr_en) d[BIT_IRQN] = wr_irqn;
    if (ev.irq || (ev.stop && !is_master)) d[BIT_IRQN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 5'b1_0000;
    else        q <= d;
  end

  assign flags = q;
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_enable,
  input  logic              addr_only,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_addr_done,
  input  logic              addr_rw,
  input  logic              addr_gcall,
  input  logic              addr_match,
  input  logic              ev_bit_rx,
  input  logic              bit_val,
  input  logic              ev_byte_done,
  input  logic              ev_start_blocked,
  input  logic              ev_irq,
  output logic [STAT_W-1:0] status
);
  bus_ev_t    ev;
  mode_e      mode, wr_mode;
  logic       busy;
  logic [4:0] flags;

  assign ev = '{start: ev_start, stop: ev_stop, arb_lost: ev_arb_lost,
                nack: ev_nack, addr_done: ev_addr_done, addr_rw: addr_rw,
                addr_gcall: addr_gcall, addr_match: addr_match,
                bit_rx: ev_bit_rx, bit_val: bit_val, byte_done: ev_byte_done,
                start_blocked: ev_start_blocked, irq: ev_irq};
  assign wr_mode = mode_e'(wr_data[BIT_MASTER:BIT_XMIT]);

  i2cs_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ev(ev), .addr_only(addr_only),
    .wr_en(wr_en), .wr_mode(wr_mode), .mode(mode)
  );

  i2cs_busy u_busy (
    .clk(clk), .rst_n(rst_n), .enable(if_enable), .ev(ev),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_busy(wr_data[BIT_BUSY]), .busy(busy)
  );

  i2cs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .is_master(mode[1]),
    .wr_en(wr_en), .wr_irqn(wr_data[BIT_IRQN]), .flags(flags)
  );

  assign status = {mode, busy, flags};
endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_enable,
  input logic       addr_only,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       ev_nack,
  input logic       ev_addr_done,
  input logic       addr_rw,
  input logic       addr_gcall,
  input logic       addr_match,
  input logic       ev_bit_rx,
  input logic       bit_val,
  input logic       ev_byte_done,
  input logic       ev_start_blocked,
  input logic       ev_irq,
  input logic [7:0] status
);
  AST_STOP_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> status[7:5] == 3'b000); // R7
  AST_DISABLED_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !if_enable |=> !status[5]); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !ev_stop && if_enable) |=> status[5]); // R3
  AST_BUSY_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:6] != 2'b11 && !ev_start && !ev_stop && if_enable)
      |=> status[5] == $past(status[5])); // R5
  AST_ARB_LOSS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> (!status[6] && status[3])); // R6
  AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_start && !ev_stop && !ev_arb_lost && !ev_addr_done && !ev_bit_rx)
      |=> status[3:0] == $past(status[3:0])); // R9
  AST_IRQ_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> !status[4]); // R10
  AST_HW_OVER_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_blocked && wr_en) |=> !status[7]); // R11
endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (.*);

// File: tb/tb_i2c_stat_reg.sv
module tb_i2c_stat_reg;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_enable = 1'b1, addr_only = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ev_start = 0, ev_stop = 0, ev_arb_lost = 0, ev_nack = 0, ev_addr_done = 0;
  logic addr_rw = 0, addr_gcall = 0, addr_match = 0, ev_bit_rx = 0, bit_val = 0;
  logic ev_byte_done = 0, ev_start_blocked = 0, ev_irq = 0;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_mst, m_tx, m_busy, m_irqn, m_arb, m_gc, m_hit, m_last, m_pend;

  i2c_stat_reg dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_word();
    return {m_mst, m_tx, m_busy, m_irqn, m_arb, m_hit, m_gc, m_last};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_fail++;
      $display("FAIL %s: status=%02h expected=%02h", tag, status, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_nack = 0;
    ev_addr_done = 0; ev_bit_rx = 0; ev_byte_done = 0; ev_start_blocked = 0;
    ev_irq = 0;
  endtask

  // inputs are already driven; advance one clock and compare with the model
  task automatic step(input string tag);
    bit n_mst, n_tx, n_busy, n_irqn, n_arb, n_gc, n_hit, n_last, n_pend;
    n_mst = m_mst; n_tx = m_tx; n_busy = m_busy; n_irqn = m_irqn;
    n_arb = m_arb; n_gc = m_gc; n_hit = m_hit; n_last = m_last; n_pend = m_pend;
    if (wr_en) begin
      n_mst = wr_data[7]; n_tx = wr_data[6]; n_irqn = wr_data[4];
      if (wr_data[7:6] == 2'b11) n_busy = wr_data[5];
    end
    if (ev_addr_done && !addr_only && !m_mst && !m_tx) n_tx = addr_rw;
    if (ev_arb_lost || ev_stop || ev_start_blocked) n_tx = 0;
    if (!m_mst && (ev_start || ev_nack)) n_tx = 0;
    if (m_pend && ev_byte_done) begin n_mst = 0; n_pend = 0; end
    if (ev_stop) n_pend = 0;
    if (ev_arb_lost) n_pend = 1;
    if (ev_stop || ev_start_blocked) n_mst = 0;
    if (ev_start) n_busy = 1;
    if (ev_stop) n_busy = 0;
    if (!if_enable) n_busy = 0;
    if (ev_irq || (ev_stop && !m_mst)) n_irqn = 0;
    if (ev_start) n_arb = 0;
    if (ev_arb_lost) n_arb = 1;
    if (ev_addr_done) begin n_gc = addr_gcall; n_hit = addr_match; end
    if (ev_stop) begin n_gc = 0; n_hit = 0; end
    if (ev_bit_rx) n_last = bit_val;
    @(posedge clk);
    @(negedge clk);
    m_mst = n_mst; m_tx = n_tx; m_busy = n_busy; m_irqn = n_irqn;
    m_arb = n_arb; m_gc = n_gc; m_hit = n_hit; m_last = n_last; m_pend = n_pend;
    check(tag, model_word());
    idle_inputs();
  endtask

  task automatic cpu_write(input logic [7:0] v, input string tag);
    wr_en = 1; wr_data = v;
    step(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: status=%02h expected=done", status);
    summary();
  end

  initial begin
    m_irqn = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset value", 8'h10);
    @(negedge clk);
    check("R1 reset value held", 8'h10);

    // R2 mode encodings
    cpu_write(8'hC0, "R2 master transmit");
    cpu_write(8'h80, "R2 master receive");
    cpu_write(8'h40, "R2 slave transmit");
    cpu_write(8'h10, "R2 slave receive");

    // R5 busy write only with master transmit selected
    cpu_write(8'h30, "R5 busy write ignored in slave");
    cpu_write(8'hB0, "R5 busy write ignored in master receive");
    cpu_write(8'hF0, "R5 busy write accepted");
    cpu_write(8'hD0, "R5 busy cleared by write");

    // R3 START / STOP
    ev_start = 1; step("R3 start sets busy");
    ev_stop = 1; step("R3 stop clears busy and mode");
    ev_start = 1; ev_stop = 1; step("R3 stop wins over start");

    // R4 disable
    ev_start = 1; step("R3 busy again");
    if_enable = 0; step("R4 disable clears busy");
    ev_start = 1; step("R4 start ignored while disabled");
    cpu_write(8'hF0, "R4 write ignored while disabled");
    if_enable = 1; step("R4 enable restored");

    // R7 deferred master clear after arbitration loss
    cpu_write(8'hF0, "R7 enter master transmit");
    ev_arb_lost = 1; step("R7 loss keeps master, clears transmit");
    repeat (3) step("R7 master held until byte end");
    ev_byte_done = 1; step("R7 byte end clears master");
    cpu_write(8'hC0, "R7 master again");
    ev_start_blocked = 1; step("R7 blocked start clears master");

    // R6 transmit clears in slave
    cpu_write(8'h50, "R6 slave transmit");
    ev_nack = 1; step("R6 nack clears transmit in slave");
    cpu_write(8'h50, "R6 slave transmit again");
    ev_start = 1; step("R6 start clears transmit in slave");
    cpu_write(8'hD0, "R6 master transmit");
    ev_nack = 1; step("R6 nack keeps transmit in master");
    ev_stop = 1; step("R6 stop clears transmit");

    // R8 address R/W capture
    cpu_write(8'h10, "R8 slave receive");
    ev_addr_done = 1; addr_rw = 1; addr_match = 1; step("R8 rw=1 sets transmit");
    ev_addr_done = 1; addr_rw = 0; step("R8 no capture outside slave receive");
    cpu_write(8'h10, "R8 back to slave receive");
    addr_only = 1; ev_addr_done = 1; addr_rw = 1; step("R8 address-only mode blocks capture");
    addr_only = 0;

    // R9 read-only bits
    ev_bit_rx = 1; bit_val = 1; ev_addr_done = 1; addr_gcall = 1; addr_match = 1; addr_rw = 0;
    step("R9 flags loaded");
    cpu_write(8'h10, "R9 write leaves bits 3:0");
    ev_arb_lost = 1; ev_start = 1; step("R9 arb flag set wins over start");
    ev_start = 1; step("R9 start clears arb flag");
    ev_stop = 1; step("R9 stop clears call and match");

    // R10 interrupt flag
    cpu_write(8'h10, "R10 no request");
    ev_irq = 1; step("R10 request drives bit 4 low");
    cpu_write(8'h10, "R10 write restores bit 4");
    ev_stop = 1; step("R10 stop in slave requests");
    cpu_write(8'h90, "R10 master");
    ev_stop = 1; step("R10 stop in master no request");

    // R11 collisions
    wr_en = 1; wr_data = 8'h10; ev_irq = 1; step("R11 irq beats write");
    wr_en = 1; wr_data = 8'hF0; ev_stop = 1; step("R11 stop beats write");
    wr_en = 1; wr_data = 8'h50; ev_arb_lost = 1; step("R11 arb loss beats transmit write");

    // random mixture against the model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en = (r[3:0] == 0); wr_data = $urandom;
      ev_start = (r[7:4] == 1); ev_stop = (r[11:8] == 2);
      ev_arb_lost = (r[15:12] == 3); ev_nack = (r[19:16] == 4);
      ev_addr_done = (r[23:20] == 5); addr_rw = r[24]; addr_gcall = r[25];
      addr_match = r[26]; ev_bit_rx = r[27]; bit_val = r[28];
      ev_byte_done = (r[31:29] == 0); ev_start_blocked = (r[11:4] == 8'h77);
      ev_irq = (r[19:12] == 8'h99); if_enable = (r[23:16] != 0);
      addr_only = (r[31:28] == 4'hF);
      step("RAND mix");
    end
    if_enable = 1;
    summary();
  end
endmodule